// File: doc/BRIEF.md
# Prescaled Countdown Timer Channel

This block is one countdown channel meant for a core's private peripheral window. The same module serves either as a general timer or as a watchdog instance. Software sees four 32-bit word registers: a reload value, the live counter, a control word and an interrupt status word. While the channel is enabled and the counter is not zero, the counter drops by one every (prescale + 1) clock cycles. When it reaches zero, a status flag is raised. In auto-reload mode the counter then refills from the reload value and keeps counting. In one-shot mode it stays at zero.

The interrupt request is a one-cycle pulse. It is raised only when the status flag goes from clear to set. Software clears the flag by writing a one to it. Reads are combinational from the address. A write takes effect on the clock edge at which `wr_en` is sampled high. Reset is synchronous and active-low.

Top module: `countdown_timer_chan`

## Requirements
- R1: After reset every register reads zero and `irq` is low. The word index is `addr[ADDR_W-1:2]`: 0 is the reload value, 1 is the counter, 2 is control, 3 is status. Any word index above 3 reads as zero, and a write to it changes nothing. Control reads back bit 0 (enable), bit 1 (auto-reload) and bits 15:8 (prescale); all other control bits read as zero.
- R2: A write to word 0 sets both the reload value and the counter to the written data. A write to word 1 sets only the counter and leaves the reload value unchanged.
- R3: While enabled with a nonzero counter, the counter decrements once every (prescale + 1) cycles. The prescale phase restarts on any write to word 0 or word 1, and it restarts when the channel starts running. The first decrement after a start or a write therefore falls (prescale + 1) edges later. A disabled channel holds its counter.
- R4: When a decrement takes the counter from 1 to 0, status bit 0 becomes 1. In one-shot mode (bit 1 clear) the counter stays at zero and counting stops.
- R5: In auto-reload mode the expiring decrement loads the reload value instead of zero, and counting continues with the same period.
- R6: Status is write-one-to-clear. Writing word 3 with bit 0 set clears the flag, and writing 0 leaves it unchanged. If an expiry occurs in the same cycle as a clear, the expiry wins.
- R7: `irq` is high for exactly one cycle, in the cycle right after the edge where status goes from 0 to 1. An expiry while status is already 1 produces no pulse.
- R8: Reading word 1 returns zero whenever the channel is disabled or the counter is zero; otherwise it returns the counter.
- R9: A control write that takes enable from 0 to 1 with auto-reload set, while the counter is zero, first loads the counter from the reload value.
- R10: A zero counter never starts a countdown. Enabling in one-shot mode with a zero counter produces no expiry and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address; word index in bits ADDR_W-1:2 |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situation to reach from the ports is a second expiry that lands while the status flag is still set, so that the pulse must be suppressed. The stimulus runs a short auto-reload period, deliberately leaves the status uncleared, and samples `irq` on the edge of the next expiry. The restart of the prescale phase is also hidden from the ports. To expose it, the bench rewrites the counter partway through a prescale period and then checks the counter on the edge before and the edge after the expected decrement. Random one-shot runs with random counts and prescale values probe the counter at random moments against a bench model.

// File: rtl/ctmr_pkg.sv
// Shared register indices and control bit positions for the countdown timer.
// Assumes a 32-bit control word with prescale in bits starting at CTRL_PRE_LSB.
package ctmr_pkg;
    typedef enum logic [1:0] {
        IDX_RELOAD = 2'd0,
        IDX_COUNT  = 2'd1,
        IDX_CTRL   = 2'd2,
        IDX_STAT   = 2'd3
    } reg_idx_e;

    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_AR_BIT  = 1;
    localparam int unsigned CTRL_PRE_LSB = 8;
endpackage

// File: rtl/ctmr_prescaler.sv
// Prescale phase counter: pulses tick once per (div + 1) running cycles.
// Assumes restart and a stopped channel both return the phase to zero.
module ctmr_prescaler #(
    parameter int unsigned PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PRE_W-1:0] div,
    output logic             tick
);
    logic [PRE_W-1:0] phase_q;

    assign tick = run && !restart && (phase_q == div);

    // Advance the phase while running; wrap at div, clear on restart or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || restart || (phase_q == div)) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/ctmr_counter.sv
// Down counter with direct write, enable-time fill and expiry reload.
// Assumes tick only arrives while the counter is nonzero.
module ctmr_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              fill,
    input  logic [DATA_W-1:0] reload_val,
    input  logic              tick,
    input  logic              auto_reload,
    output logic [DATA_W-1:0] cnt_q,
    output logic              expire
);
    localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

    assign expire = tick && (cnt_q == ONE);

    // Update the count: writes first, then enable fill, then a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (wr_cnt) begin
            cnt_q <= wr_val;
        end else if (fill) begin
            cnt_q <= reload_val;
        end else if (expire) begin
            cnt_q <= auto_reload ? reload_val : '0;
        end else if (tick) begin
            cnt_q <= cnt_q - ONE;
        end
    end
endmodule

// File: rtl/ctmr_status_irq.sv
// Status flag with write-one-to-clear, plus a rising-edge interrupt pulse.
// Assumes set has priority over clear in the same cycle.
module ctmr_status_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic status_q,
    output logic irq_q
);
    logic status_nxt;

    assign status_nxt = (status_q && !clr) || set;

    // Hold the flag and pulse irq only on a 0-to-1 change of the flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= status_nxt;
            irq_q    <= status_nxt && !status_q;
        end
    end
endmodule

// File: rtl/countdown_timer_chan.sv
// Countdown timer channel top: register decode, control and read mux.
// Assumes ADDR_W >= 4 and the prescale field fits inside DATA_W.
module countdown_timer_chan #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned PRE_W  = 8,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    import ctmr_pkg::*;

    localparam int unsigned IDX_W   = ADDR_W - 2;
    localparam int unsigned PRE_MSB = CTRL_PRE_LSB + PRE_W - 1;

    logic [IDX_W-1:0]  word_idx;
    logic              mapped;
    reg_idx_e          sel;
    logic              wr_reload, wr_count, wr_ctrl, wr_stat;
    logic [DATA_W-1:0] reload_q;
    logic              en_q, ar_q;
    logic [PRE_W-1:0]  pre_q;
    logic [DATA_W-1:0] cnt_q;
    logic              run, tick, expire, fill, status_q;

    assign word_idx  = addr[ADDR_W-1:2];
    assign mapped    = (word_idx >> 2) == '0;
    assign sel       = reg_idx_e'(word_idx[1:0]);
    assign wr_reload = wr_en && mapped && (sel == IDX_RELOAD);
    assign wr_count  = wr_en && mapped && (sel == IDX_COUNT);
    assign wr_ctrl   = wr_en && mapped && (sel == IDX_CTRL);
    assign wr_stat   = wr_en && mapped && (sel == IDX_STAT);

    assign run  = en_q && (cnt_q != '0);
    assign fill = wr_ctrl && wr_data[CTRL_EN_BIT] && !en_q
                  && wr_data[CTRL_AR_BIT] && (cnt_q == '0);

    // Hold the reload value and the control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            en_q     <= 1'b0;
            ar_q     <= 1'b0;
            pre_q    <= '0;
        end else begin
            if (wr_reload) begin
                reload_q <= wr_data;
            end
            if (wr_ctrl) begin
                en_q  <= wr_data[CTRL_EN_BIT];
                ar_q  <= wr_data[CTRL_AR_BIT];
                pre_q <= wr_data[PRE_MSB:CTRL_PRE_LSB];
            end
        end
    end

    ctmr_prescaler #(.PRE_W(PRE_W)) presc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr_reload || wr_count),
        .div     (pre_q),
        .tick    (tick)
    );

    ctmr_counter #(.DATA_W(DATA_W)) count_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_cnt      (wr_reload || wr_count),
        .wr_val      (wr_data),
        .fill        (fill),
        .reload_val  (reload_q),
        .tick        (tick),
        .auto_reload (ar_q),
        .cnt_q       (cnt_q),
        .expire      (expire)
    );

    ctmr_status_irq stat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (expire),
        .clr      (wr_stat && wr_data[0]),
        .status_q (status_q),
        .irq_q    (irq)
    );

    // Select read data for the addressed word; unmapped words read zero.
    always_comb begin
        rd_data = '0;
        if (mapped) begin
            unique case (sel)
                IDX_RELOAD: rd_data = reload_q;
                IDX_COUNT:  rd_data = run ? cnt_q : '0;
                IDX_CTRL: begin
                    rd_data[CTRL_EN_BIT]          = en_q;
                    rd_data[CTRL_AR_BIT]          = ar_q;
                    rd_data[PRE_MSB:CTRL_PRE_LSB] = pre_q;
                end
                IDX_STAT:   rd_data[0] = status_q;
            endcase
        end
    end
endmodule

// File: rtl/ctmr_checker.sv
// Property checker for the countdown timer channel, bound to the top.
// Assumes it observes internal count, enable, status and expiry signals.
module ctmr_checker #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq,
    input logic              en,
    input logic [DATA_W-1:0] cnt,
    input logic              status,
    input logic              expire
);
    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] W_COUNT = IDX_W'(1);
    localparam logic [IDX_W-1:0] W_STAT  = IDX_W'(3);

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);  // R7
    AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status && !$past(status)));  // R7
    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> status);  // R4
    AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[ADDR_W-1:2] == W_STAT && wr_data[0] && !expire) |=> !status);  // R6
    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !wr_en) |=> (cnt == '0));  // R10
    AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !wr_en) |=> $stable(cnt));  // R3
    AST_CNT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && addr[ADDR_W-1:2] == W_COUNT) |-> (rd_data == '0));  // R8
endmodule

bind countdown_timer_chan ctmr_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq     (irq),
    .en      (en_q),
    .cnt     (cnt_q),
    .status  (status_q),
    .expire  (expire)
);

// File: tb/countdown_timer_chan_tb_top.sv
`timescale 1ns/100ps
module countdown_timer_chan_tb_top;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    countdown_timer_chan #(.DATA_W(DATA_W), .PRE_W(8), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Word offsets and control encodings taken from the requirements.
    localparam logic [ADDR_W-1:0] A_RELOAD = 6'h00, A_COUNT = 6'h04,
                                  A_CTRL = 6'h08, A_STAT = 6'h0C;
    localparam logic [31:0] C_EN = 32'h1, C_AR = 32'h2;

    function automatic logic [31:0] ctrl_word(bit en, bit ar, int pre);
        return {16'h0, pre[7:0], 6'h0, ar, en};
    endfunction

    // One-shot counter value k edges after start with count n, prescale p.
    function automatic int exp_count(int n, int p, int k);
        int dec = k / (p + 1);
        return (dec >= n) ? 0 : n - dec;
    endfunction

    function automatic int fire_edges(int n, int p);
        return n * (p + 1);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        addr = a;
        #0.1;
        d = rd_data;
    endtask

    task automatic wait_edges(int m);
        repeat (m) begin @(posedge clk); @(negedge clk); end
    endtask

    initial begin
        logic [31:0] v;
        int seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state and decode
        reg_rd(A_RELOAD, v); check("R1 reset reload", v, 0);
        reg_rd(A_COUNT, v);  check("R1 reset count", v, 0);
        reg_rd(A_CTRL, v);   check("R1 reset ctrl", v, 0);
        reg_rd(A_STAT, v);   check("R1 reset status", v, 0);
        check("R1 reset irq", irq, 0);
        reg_wr(A_RELOAD, 7);
        reg_wr(6'h14, 32'h55);
        reg_rd(6'h10, v); check("R1 unmapped read", v, 0);
        reg_rd(6'h3C, v); check("R1 unmapped read high", v, 0);
        reg_rd(A_RELOAD, v); check("R1 unmapped write ignored", v, 7);
        reg_wr(A_CTRL, 32'hFFFF_FFFE);
        reg_rd(A_CTRL, v); check("R1 ctrl readback", v, 32'h0000_FF02);
        reg_wr(A_CTRL, 0);

        // R2 reload writes counter too; counter write leaves reload
        reg_wr(A_RELOAD, 9);
        reg_wr(A_COUNT, 4);
        reg_rd(A_RELOAD, v); check("R2 reload kept", v, 9);
        reg_wr(A_CTRL, ctrl_word(1, 0, 5));
        reg_rd(A_COUNT, v); check("R2 counter write", v, 4);
        reg_wr(A_RELOAD, 6);
        reg_rd(A_COUNT, v); check("R2 reload sets counter", v, 6);

        // R8 disabled reads zero, count held across disable
        reg_wr(A_CTRL, 0);
        reg_rd(A_COUNT, v); check("R8 disabled read zero", v, 0);
        reg_wr(A_CTRL, ctrl_word(1, 0, 5));
        reg_rd(A_COUNT, v); check("R8 held on re-enable", v, 6);

        // R3 prescale restart on counter write
        reg_wr(A_CTRL, 0);
        reg_wr(A_COUNT, 10);
        reg_wr(A_CTRL, ctrl_word(1, 0, 3));
        wait_edges(2);
        reg_wr(A_COUNT, 10);
        wait_edges(3);
        reg_rd(A_COUNT, v); check("R3 phase restarted", v, 10);
        wait_edges(1);
        reg_rd(A_COUNT, v); check("R3 first decrement", v, 9);
        reg_wr(A_CTRL, 0);
        reg_wr(A_STAT, 1);

        // R3 R4 R7 random one-shot runs
        for (int it = 0; it < 10; it++) begin
            int n = 1 + int'($urandom % 12);
            int p = int'($urandom % 4);
            int t = fire_edges(n, p);
            int k = int'($urandom % t);
            reg_wr(A_CTRL, 0);
            reg_wr(A_STAT, 1);
            reg_wr(A_RELOAD, n);
            reg_wr(A_CTRL, ctrl_word(1, 0, p));
            wait_edges(k);
            reg_rd(A_COUNT, v); check("R3 random count", v, exp_count(n, p, k));
            wait_edges(t - k - 1);
            check("R7 no early irq", irq, 0);
            reg_rd(A_STAT, v); check("R4 status before expiry", v, 0);
            wait_edges(1);
            check("R7 irq pulse", irq, 1);
            reg_rd(A_STAT, v); check("R4 status set", v, 1);
            reg_rd(A_COUNT, v); check("R4 one-shot zero", v, 0);
            wait_edges(1);
            check("R7 irq one cycle", irq, 0);
        end

        // R5 auto-reload, R7 suppression when status already set
        reg_wr(A_CTRL, 0);
        reg_wr(A_STAT, 1);
        reg_wr(A_RELOAD, 3);
        reg_wr(A_CTRL, ctrl_word(1, 1, 1));
        wait_edges(fire_edges(3, 1));
        check("R5 first expiry irq", irq, 1);
        reg_rd(A_COUNT, v); check("R5 reloaded", v, 3);
        wait_edges(fire_edges(3, 1));
        check("R7 no pulse while set", irq, 0);
        reg_rd(A_COUNT, v); check("R5 second reload", v, 3);
        reg_rd(A_STAT, v); check("R5 status still set", v, 1);

        // R6 write-one-to-clear
        reg_wr(A_CTRL, 0);
        reg_wr(A_STAT, 0);
        reg_rd(A_STAT, v); check("R6 write zero keeps", v, 1);
        reg_wr(A_STAT, 32'hFFFF_FFFF);
        reg_rd(A_STAT, v); check("R6 write one clears", v, 0);

        // R9 enable fill from reload
        reg_wr(A_RELOAD, 5);
        reg_wr(A_COUNT, 0);
        reg_wr(A_CTRL, C_EN | C_AR);
        reg_rd(A_COUNT, v); check("R9 fill on enable", v, 5);

        // R10 zero count never starts in one-shot
        reg_wr(A_CTRL, 0);
        reg_wr(A_STAT, 1);
        reg_wr(A_COUNT, 0);
        reg_wr(A_CTRL, C_EN);
        reg_rd(A_COUNT, v); check("R10 stays zero", v, 0);
        wait_edges(20);
        reg_rd(A_STAT, v); check("R10 no expiry", v, 0);
        check("R10 no irq", irq, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule